// File: doc/BRIEF.md
# Execute ALU and Condition Unit

This block is the arithmetic unit of the execute stage of a small 32-bit integer core whose operations work on registers only. A 4-bit function code selects add, subtract, AND or XOR between two operands. The result leaves combinationally in the same cycle. When the instruction is an integer operation, the decode logic raises a strobe. At the next clock edge that strobe loads three flags: zero, sign and signed overflow.

A second 4-bit selector picks one of seven conditions, evaluated from the stored flags. Jumps and conditional moves share this selector; the unconditional entry serves plain jumps and plain register moves. An address mode turns the unit into a plain adder for effective-address and stack-pointer arithmetic. In that mode the function code is ignored and the flags are never touched.

Top module: `exec_alu`

## Requirements
- R1: With `addr_mode` low and `fn_sel` = 0, `result` equals `opnd_a + opnd_b` modulo 2^32 in the same cycle.
- R2: With `addr_mode` low and `fn_sel` = 1, `result` equals `opnd_b - opnd_a` modulo 2^32.
- R3: With `addr_mode` low, `fn_sel` = 2 gives bitwise AND and `fn_sel` = 3 gives bitwise XOR of the operands; codes 4 to 15 give a result of zero.
- R4: When `set_cc` is high and `addr_mode` is low at a rising edge, after that edge `flag_z` is 1 exactly when the result was zero, and `flag_s` equals the result's bit 31.
- R5: On such a load, `flag_o` after an add is set when both operands have the same sign and the result's sign differs from it. After a subtract it is set when the signs of A and B differ and the result's sign differs from B's. After AND, XOR or codes 4 to 15 it is cleared.
- R6: At an edge where `set_cc` is low, the three flags keep their values.
- R7: While `rst_n` is low, the flags are set at the clock edge to `flag_z` = 1, `flag_s` = 0, `flag_o` = 0.
- R8: With `addr_mode` high, `result` equals `opnd_a + opnd_b` for every `fn_sel`, and the flags keep their values even when `set_cc` is high.
- R9: `cond_true` follows `cond_sel` combinationally from the stored flags. The encodings are: 0 always 1, 1 = (S^O)|Z, 2 = S^O, 3 = Z, 4 = !Z, 5 = !(S^O), 6 = !(S^O)&!Z. Codes 7 to 15 give 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| fn_sel | input | 4 | Operation code: 0 add, 1 subtract, 2 AND, 3 XOR |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| set_cc | input | 1 | Load the flags at the next edge |
| addr_mode | input | 1 | Plain add for address arithmetic; blocks the flag load |
| cond_sel | input | 4 | Condition code for a jump or conditional move |
| result | output | 32 | Combinational result |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored overflow flag |
| cond_true | output | 1 | Selected condition holds |

## Verification
On every cycle the assertions check these behaviours: the hold of the flags when no load occurs or address mode is active, and the zero and sign flags against the previous cycle's result. They also check the add overflow rule, the clearing of overflow by the logic operations, the reset values, and several of the condition decodes. The bench's sweeps show what the assertions only sample: the values of every operation over a grid of corner operands, the subtract overflow boundary, and all sixteen condition codes against each flag state that can be reached. They also show that address mode overrides every function code.

// File: rtl/alu_pkg.sv
// Package: encodings shared by the execute ALU and its condition decoder.
// Assumes 4-bit function and condition selectors.
package alu_pkg;
    typedef enum logic [3:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } fn_code_e;

    typedef enum logic [3:0] {
        CND_ALWAYS = 4'd0,
        CND_LE     = 4'd1,
        CND_LT     = 4'd2,
        CND_EQ     = 4'd3,
        CND_NE     = 4'd4,
        CND_GE     = 4'd5,
        CND_GT     = 4'd6
    } cond_code_e;

    typedef struct packed {
        logic z;
        logic s;
        logic o;
    } flags_t;
endpackage

// File: rtl/alu_datapath.sv
// Combinational datapath: computes the result and the overflow candidate.
// Assumes subtract means B minus A; address mode forces a plain add.
module alu_datapath #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       fn_sel,
    input  logic             addr_mode,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] res,
    output logic             ovf
);
    import alu_pkg::*;
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum_ab;
    logic [WIDTH-1:0] diff_ba;

    assign sum_ab  = opnd_a + opnd_b;
    assign diff_ba = opnd_b - opnd_a;

    // Select the result and its signed-overflow indication.
    always_comb begin
        res = '0;
        ovf = 1'b0;
        if (addr_mode) begin
            res = sum_ab;
        end else begin
            case (fn_sel)
                FN_ADD: begin
                    res = sum_ab;
                    ovf = (opnd_a[MSB] == opnd_b[MSB]) && (sum_ab[MSB] != opnd_a[MSB]);
                end
                FN_SUB: begin
                    res = diff_ba;
                    ovf = (opnd_a[MSB] != opnd_b[MSB]) && (diff_ba[MSB] != opnd_b[MSB]);
                end
                FN_AND:  res = opnd_a & opnd_b;
                FN_XOR:  res = opnd_a ^ opnd_b;
                default: res = '0;
            endcase
        end
    end
endmodule

// File: rtl/flag_store.sv
// Flag register: holds zero, sign and overflow; loads on a strobe.
// Assumes a synchronous active-low reset to Z=1, S=0, O=0.
module flag_store (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  alu_pkg::flags_t nxt,
    output alu_pkg::flags_t cur
);
    // Reset, load or hold the three flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '{z: 1'b1, s: 1'b0, o: 1'b0};
        end else if (load) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/cond_decode.sv
// Condition decoder shared by jumps and conditional moves.
// Assumes stored flags; unused codes decode to false.
module cond_decode (
    input  logic [3:0]      cond_sel,
    input  alu_pkg::flags_t fl,
    output logic            take
);
    import alu_pkg::*;
    logic less;

    assign less = fl.s ^ fl.o;

    // Map the condition code onto the flag expression.
    always_comb begin
        case (cond_sel)
            CND_ALWAYS: take = 1'b1;
            CND_LE:     take = less | fl.z;
            CND_LT:     take = less;
            CND_EQ:     take = fl.z;
            CND_NE:     take = ~fl.z;
            CND_GE:     take = ~less;
            CND_GT:     take = ~less & ~fl.z;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/exec_alu.sv
// Execute ALU top: datapath, flag register and condition decoder.
// Assumes set_cc is raised only for integer-operation instructions.
module exec_alu #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       fn_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             set_cc,
    input  logic             addr_mode,
    input  logic [3:0]       cond_sel,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_s,
    output logic             flag_o,
    output logic             cond_true
);
    import alu_pkg::*;

    logic   ovf;
    logic   ld;
    flags_t nxt_fl;
    flags_t cur_fl;

    alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .fn_sel    (fn_sel),
        .addr_mode (addr_mode),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .res       (result),
        .ovf       (ovf)
    );

    assign ld     = set_cc & ~addr_mode;
    assign nxt_fl = '{z: (result == '0), s: result[WIDTH-1], o: ovf};

    flag_store u_fl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld),
        .nxt   (nxt_fl),
        .cur   (cur_fl)
    );

    cond_decode u_cd (
        .cond_sel (cond_sel),
        .fl       (cur_fl),
        .take     (cond_true)
    );

    assign flag_z = cur_fl.z;
    assign flag_s = cur_fl.s;
    assign flag_o = cur_fl.o;
endmodule

// File: rtl/exec_alu_chk.sv
// Checker for exec_alu: temporal properties on ports and flag state.
// Assumes it is bound to every exec_alu instance.
module exec_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       fn_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             set_cc,
    input logic             addr_mode,
    input logic [3:0]       cond_sel,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_s,
    input logic             flag_o,
    input logic             cond_true
);
    AST_RESET_FLAGS: assert property (@(posedge clk) !rst_n |=> (flag_z && !flag_s && !flag_o)); // R7
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_cc || addr_mode) |=> ($stable(flag_z) && $stable(flag_s) && $stable(flag_o))); // R6
    AST_ADDR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode |=> $stable({flag_z, flag_s, flag_o})); // R8
    AST_ZERO_SIGN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && !addr_mode) |=> (flag_z == ($past(result) == '0)) && (flag_s == $past(result[WIDTH-1]))); // R4
    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && !addr_mode && fn_sel == 4'd0) |=>
        (flag_o == $past((opnd_a[WIDTH-1] == opnd_b[WIDTH-1]) && (result[WIDTH-1] != opnd_a[WIDTH-1])))); // R5
    AST_LOGIC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && !addr_mode && (fn_sel == 4'd2 || fn_sel == 4'd3)) |=> !flag_o); // R5
    AST_ADDR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode |-> (result == opnd_a + opnd_b)); // R8
    AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd0) |-> cond_true); // R9
    AST_COND_NE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd4) |-> (cond_true == !flag_z)); // R9
    AST_COND_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel > 4'd6) |-> !cond_true); // R9
endmodule

bind exec_alu exec_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fn_sel    (fn_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .set_cc    (set_cc),
    .addr_mode (addr_mode),
    .cond_sel  (cond_sel),
    .result    (result),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_o    (flag_o),
    .cond_true (cond_true)
);

// File: tb/tb_exec_alu.sv
// Bench for exec_alu: sweeps operations over corner operands and all conditions.
module tb_exec_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fn_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        set_cc = 1'b0;
    logic        addr_mode = 1'b0;
    logic [3:0]  cond_sel = '0;
    logic [31:0] result;
    logic        flag_z, flag_s, flag_o, cond_true;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic mz = 1'b1, ms = 1'b0, mo = 1'b0;

    always #2.5 clk = ~clk;

    exec_alu dut (.*);

    logic [31:0] pat [8] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000,
                             32'hffff_ffff, 32'h1234_5678, 32'h0000_ffff, 32'hedcb_a988};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_res(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        case (f)
            4'd0: return a + b;
            4'd1: return b - a;
            4'd2: return a & b;
            4'd3: return a ^ b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        r = exp_res(f, a, b);
        if (f == 4'd0) return (a[31] == b[31]) && (r[31] != a[31]);
        if (f == 4'd1) return (a[31] != b[31]) && (r[31] != b[31]);
        return 1'b0;
    endfunction

    function automatic logic exp_cond(input logic [3:0] c);
        case (c)
            4'd0: return 1'b1;
            4'd1: return (ms ^ mo) | mz;
            4'd2: return ms ^ mo;
            4'd3: return mz;
            4'd4: return ~mz;
            4'd5: return ~(ms ^ mo);
            4'd6: return ~(ms ^ mo) & ~mz;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk_flags(input string tag);
        chk({tag, " flags"}, {29'd0, flag_z, flag_s, flag_o}, {29'd0, mz, ms, mo});
    endtask

    task automatic sweep_cond();
        for (int c = 0; c < 16; c++) begin
            cond_sel = c[3:0];
            #0.2;
            chk("R9 condition", {31'd0, cond_true}, {31'd0, exp_cond(c[3:0])});
        end
    endtask

    // Apply one operation, check the result, cross an edge, check the flags.
    task automatic apply(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic cc, input logic am);
        logic [31:0] er;
        @(negedge clk);
        fn_sel = f; opnd_a = a; opnd_b = b; set_cc = cc; addr_mode = am;
        #0.5;
        er = am ? a + b : exp_res(f, a, b);
        if (am) chk("R8 address add", result, er);
        else if (f == 4'd0) chk("R1 add", result, er);
        else if (f == 4'd1) chk("R2 sub", result, er);
        else chk("R3 logic or unused", result, er);
        @(posedge clk);
        #0.5;
        if (cc && !am) begin
            mz = (er == 32'h0); ms = er[31]; mo = exp_ovf(f, a, b);
            chk_flags("R4 R5 load");
        end else if (am) begin
            chk_flags("R8 no load");
        end else begin
            chk_flags("R6 hold");
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        chk_flags("R7 reset");
        sweep_cond();
        @(negedge clk);
        rst_n = 1'b1;
        // Main sweep: every operation over the corner grid, flags loaded.
        for (int f = 0; f < 4; f++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    apply(f[3:0], pat[i], pat[j], 1'b1, 1'b0);
                    sweep_cond();
                end
        // Set a non-reset flag state, then show hold without strobe.
        apply(4'd0, 32'h7fff_ffff, 32'h1, 1'b1, 1'b0);
        for (int f = 0; f < 16; f++) apply(f[3:0], 32'h5, 32'h5, 1'b0, 1'b0);
        // Address mode overrides every code and blocks the load.
        for (int f = 0; f < 16; f++) apply(f[3:0], 32'hffff_fffc, 32'h100, 1'b1, 1'b1);
        sweep_cond();
        // Unused codes yield zero and clear overflow.
        apply(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
        apply(4'd9, 32'h1234, 32'h5678, 1'b1, 1'b0);
        // Reset again restores the reset flag values.
        @(negedge clk);
        rst_n = 1'b0; set_cc = 1'b0;
        @(posedge clk);
        #0.5;
        mz = 1'b1; ms = 1'b0; mo = 1'b0;
        chk_flags("R7 re-reset");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule